// File: doc/BRIEF.md
# Bit-Clock Mode and De-Emphasis Controller

This block decodes one shared input pin that can carry two different things: a free-running external bit clock, or a slow static level that selects de-emphasis. It works entirely in the master-clock domain. The frame clock and the shared pin are first brought in through synchronizers. Rising edges on the pin are then counted within each half of the frame clock, and a burst of them switches the block to external bit-clock mode. When the pin goes quiet for whole frames, the block falls back to internal bit-clock mode. In internal mode, the pin level seen at frame-clock falling edges is run-length filtered to turn de-emphasis on or off.

Alongside the pin decode, a start-up sequencer walks through four states: power-down, ratio detect, reference ramp and run. It holds the audio mute asserted until a set number of frames have passed with a locked clock ratio. It returns to an earlier state whenever the frame clock disappears or the ratio detector loses lock. The output state code is 0 for power-down, 1 for ratio detect, 2 for reference ramp and 3 for run.

Top module: `bclk_mode_ctrl`

## Requirements
- R1: After reset, the state code is 0, the mute output is 1, the external-mode flag is 0 and de-emphasis is 0.
- R2: While no frame-clock edge arrives within FRAME_TIMEOUT master-clock cycles, the state stays at power-down (code 0).
- R3: Once frame-clock edges are present, the state moves to ratio detect (code 1) and stays there, muted, until the ratio-lock input is 1.
- R4: After lock, the state is reference ramp (code 2) with mute 1 until START_FRAMES frame-clock rising edges have been seen. On that edge it enters run (code 3) and mute drops to 0.
- R5: If ratio lock drops during ramp or run, the state returns to ratio detect (code 1), mute goes to 1, and the ramp count restarts.
- R6: When the frame clock stops for FRAME_TIMEOUT master-clock cycles, the state returns to power-down (code 0) and mute goes to 1.
- R7: External mode is entered when EDGE_THRESH (16) pin rising edges occur between two consecutive frame-clock edges. With EDGE_THRESH-1 rises per half-frame, the block stays in internal mode.
- R8: External mode is left after IDLE_FRAMES (2) frame-clock rising edges pass with no pin rising edge. After only one such frame edge, the block is still in external mode.
- R9: De-emphasis is requested after the pin is sampled low at DEEMPH_RUN (5) consecutive frame-clock falling edges. Four consecutive low samples are not enough.
- R10: The de-emphasis request is withdrawn after the pin is sampled high at DEEMPH_RUN consecutive frame-clock falling edges.
- R11: The de-emphasis output is 1 only while a request is held, the block is in internal mode, and the speed input is 0 (single speed; 1 is double, 2 is quad).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to clk before sync |
| shared_pin | input | 1 | Pin carrying either an external bit clock or a de-emphasis level |
| ratio_lock | input | 1 | 1 when the clock-ratio detector has locked |
| speed_mode | input | 2 | 0 single speed, 1 double speed, 2 quad speed |
| ext_mode | output | 1 | 1 in external bit-clock mode, 0 in internal mode |
| deemph_en | output | 1 | De-emphasis enable |
| seq_state | output | 2 | Start-up state code: 0 power-down, 1 detect, 2 ramp, 3 run |
| mute | output | 1 | 1 while output data must be forced to zero |

## Verification
The hardest condition to reach from the ports is the edge-count threshold: exactly sixteen pin rises must fall inside one frame half. Fifteen rises per half must leave the mode untouched. To reach it, the bench stretches each frame half to 40 master clocks, so that a burst of up to sixteen pin pulses fits with margin between frame edges. The exit timing is then measured in whole frame periods counted from the last burst. Frame timeout and ramp length are overridden to small values, so power-down recovery and the ramp-to-run transition can be reached within a few dozen frames.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

   typedef enum logic [1:0] {
      ST_PWRDN  = 2'd0,
      ST_DETECT = 2'd1,
      ST_RAMP   = 2'd2,
      ST_RUN    = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2
   } speed_t;

endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   initial assert (STAGES >= 2) else $error("bcm_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bcm_mode_det.sv
module bcm_mode_det #(
   parameter int EDGE_THRESH = 16,
   parameter int IDLE_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_rise,
   input  logic frame_rise,
   input  logic frame_edge,
   output logic ext_mode
);

   localparam int CW = $clog2(EDGE_THRESH + 1);
   localparam int IW = $clog2(IDLE_FRAMES + 1);

   logic [CW-1:0] edge_cnt;
   logic [IW-1:0] idle_cnt;

   initial assert (EDGE_THRESH >= 2) else $error("bcm_mode_det: EDGE_THRESH below 2");
   initial assert (IDLE_FRAMES >= 1) else $error("bcm_mode_det: IDLE_FRAMES below 1");

   // rises seen since the last frame edge (either polarity)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
      end else if (frame_edge) begin
         edge_cnt <= pin_rise ? CW'(1) : '0;
      end else if (pin_rise && edge_cnt != CW'(EDGE_THRESH)) begin
         edge_cnt <= edge_cnt + CW'(1);
      end
   end

   // frame periods elapsed since the last pin rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
      end else if (pin_rise) begin
         idle_cnt <= '0;
      end else if (frame_rise && idle_cnt != IW'(IDLE_FRAMES)) begin
         idle_cnt <= idle_cnt + IW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_mode <= 1'b0;
      end else if (pin_rise && !frame_edge && edge_cnt == CW'(EDGE_THRESH - 1)) begin
         ext_mode <= 1'b1;
      end else if (!pin_rise && frame_rise && idle_cnt == IW'(IDLE_FRAMES - 1)) begin
         ext_mode <= 1'b0;
      end
   end

   AST_EXT_ENTRY_ON_PIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_mode) |-> $past(pin_rise)); // R7
   AST_EXT_EXIT_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_mode) |-> ($past(frame_rise) && !$past(pin_rise))); // R8

endmodule

// File: rtl/bcm_deemph.sv
module bcm_deemph #(
   parameter int DEEMPH_RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_fall,
   input  logic pin_lvl,
   output logic deemph_req
);

   localparam int RW = $clog2(DEEMPH_RUN + 1);

   logic          last_lvl;
   logic [RW-1:0] run_cnt;

   initial assert (DEEMPH_RUN >= 2) else $error("bcm_deemph: DEEMPH_RUN below 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_lvl   <= 1'b1;
         run_cnt    <= '0;
         deemph_req <= 1'b0;
      end else if (frame_fall) begin
         if (pin_lvl != last_lvl) begin
            last_lvl <= pin_lvl;
            run_cnt  <= RW'(1);
         end else begin
            if (run_cnt != RW'(DEEMPH_RUN)) begin
               run_cnt <= run_cnt + RW'(1);
            end
            if (run_cnt == RW'(DEEMPH_RUN - 1)) begin
               deemph_req <= ~pin_lvl;   // low level selects de-emphasis
            end
         end
      end
   end

   AST_REQ_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(deemph_req) |-> $past(frame_fall)); // R9

endmodule

// File: rtl/bcm_seq.sv
module bcm_seq
   import bcm_pkg::*;
#(
   parameter int FRAME_TIMEOUT = 2048,
   parameter int START_FRAMES  = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_edge,
   input  logic       frame_rise,
   input  logic       ratio_lock,
   output seq_state_t state,
   output logic       mute
);

   localparam int TW = $clog2(FRAME_TIMEOUT + 1);
   localparam int SW = $clog2(START_FRAMES);

   logic [TW-1:0] tmo_cnt;
   logic [SW-1:0] ramp_cnt;
   logic          present;

   initial assert (START_FRAMES >= 2) else $error("bcm_seq: START_FRAMES below 2");
   initial assert (FRAME_TIMEOUT >= 4) else $error("bcm_seq: FRAME_TIMEOUT below 4");

   assign present = (tmo_cnt != TW'(FRAME_TIMEOUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_cnt <= TW'(FRAME_TIMEOUT);
      end else if (frame_edge) begin
         tmo_cnt <= '0;
      end else if (present) begin
         tmo_cnt <= tmo_cnt + TW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_PWRDN;
         ramp_cnt <= '0;
      end else begin
         case (state)
            ST_PWRDN: if (present) state <= ST_DETECT;
            ST_DETECT: begin
               if (!present) begin
                  state <= ST_PWRDN;
               end else if (ratio_lock) begin
                  state    <= ST_RAMP;
                  ramp_cnt <= '0;
               end
            end
            ST_RAMP: begin
               if (!present) begin
                  state <= ST_PWRDN;
               end else if (!ratio_lock) begin
                  state <= ST_DETECT;
               end else if (frame_rise) begin
                  if (ramp_cnt == SW'(START_FRAMES - 1)) begin
                     state <= ST_RUN;
                  end else begin
                     ramp_cnt <= ramp_cnt + SW'(1);
                  end
               end
            end
            ST_RUN: begin
               if (!present) begin
                  state <= ST_PWRDN;
               end else if (!ratio_lock) begin
                  state <= ST_DETECT;
               end
            end
            default: state <= ST_PWRDN;
         endcase
      end
   end

   assign mute = (state != ST_RUN);

   AST_ABSENT_FORCES_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
      !present |=> state == ST_PWRDN); // R6
   AST_NO_RAMP_WITHOUT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DETECT && !ratio_lock) |=> (state == ST_DETECT || state == ST_PWRDN)); // R3
   AST_LOCK_LOSS_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !ratio_lock) |=> (state == ST_DETECT || state == ST_PWRDN)); // R5
   AST_RUN_ONLY_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> ($past(state) == ST_RAMP || $past(state) == ST_RUN)); // R4

endmodule

// File: rtl/bclk_mode_ctrl.sv
module bclk_mode_ctrl
   import bcm_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int EDGE_THRESH   = 16,
   parameter int IDLE_FRAMES   = 2,
   parameter int DEEMPH_RUN    = 5,
   parameter int FRAME_TIMEOUT = 2048,
   parameter int START_FRAMES  = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_clk,
   input  logic       shared_pin,
   input  logic       ratio_lock,
   input  logic [1:0] speed_mode,
   output logic       ext_mode,
   output logic       deemph_en,
   output logic [1:0] seq_state,
   output logic       mute
);

   logic [1:0] sync_q;
   logic       frame_s, pin_s, frame_d, pin_d;
   logic       frame_rise, frame_fall, frame_edge, pin_rise;
   logic       deemph_req;
   seq_state_t state;

   bcm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({frame_clk, shared_pin}),
      .q     (sync_q)
   );

   assign frame_s = sync_q[1];
   assign pin_s   = sync_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_d <= 1'b0;
         pin_d   <= 1'b0;
      end else begin
         frame_d <= frame_s;
         pin_d   <= pin_s;
      end
   end

   assign frame_rise = frame_s & ~frame_d;
   assign frame_fall = ~frame_s & frame_d;
   assign frame_edge = frame_rise | frame_fall;
   assign pin_rise   = pin_s & ~pin_d;

   bcm_mode_det #(.EDGE_THRESH(EDGE_THRESH), .IDLE_FRAMES(IDLE_FRAMES)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_rise   (pin_rise),
      .frame_rise (frame_rise),
      .frame_edge (frame_edge),
      .ext_mode   (ext_mode)
   );

   bcm_deemph #(.DEEMPH_RUN(DEEMPH_RUN)) u_deemph (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_fall (frame_fall),
      .pin_lvl    (pin_s),
      .deemph_req (deemph_req)
   );

   bcm_seq #(.FRAME_TIMEOUT(FRAME_TIMEOUT), .START_FRAMES(START_FRAMES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_edge (frame_edge),
      .frame_rise (frame_rise),
      .ratio_lock (ratio_lock),
      .state      (state),
      .mute       (mute)
   );

   assign seq_state = state;
   assign deemph_en = deemph_req & ~ext_mode & (speed_mode == SPD_SINGLE);

   AST_DEEMPH_HELD_ACROSS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && !frame_fall) |=> $stable(deemph_req)); // R11

endmodule

// File: tb/tb_bclk_mode_ctrl.sv
module tb_bclk_mode_ctrl;

   localparam int HALF = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic       shared_pin = 1'b1;
   logic       ratio_lock = 1'b0;
   logic [1:0] speed_mode = 2'd0;
   logic       ext_mode, deemph_en, mute;
   logic [1:0] seq_state;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bclk_mode_ctrl #(
      .FRAME_TIMEOUT (64),
      .START_FRAMES  (6)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_clk  (frame_clk),
      .shared_pin (shared_pin),
      .ratio_lock (ratio_lock),
      .speed_mode (speed_mode),
      .ext_mode   (ext_mode),
      .deemph_en  (deemph_en),
      .seq_state  (seq_state),
      .mute       (mute)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one frame half: toggle the frame clock, then emit 'rises' pin pulses
   task automatic phase(input int rises);
      frame_clk = ~frame_clk;
      for (int i = 0; i < HALF; i++) begin
         @(negedge clk);
         if (rises > 0) shared_pin = (i < 2*rises) ? i[0] : 1'b0;
      end
   endtask

   task automatic phases(input int n, input int rises);
      for (int k = 0; k < n; k++) phase(rises);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 state", seq_state, 0);
      chk("R1 mute", mute, 1);
      chk("R1 ext", ext_mode, 0);
      chk("R1 deemph", deemph_en, 0);
   endtask

   task automatic t_no_frames;
      repeat (200) @(negedge clk);
      chk("R2 state", seq_state, 0);
   endtask

   task automatic t_detect_wait;
      phases(2, 0);
      chk("R3 state", seq_state, 1);
      chk("R3 mute", mute, 1);
   endtask

   task automatic t_ramp_to_run;
      ratio_lock = 1'b1;
      phases(10, 0);
      chk("R4 state before last", seq_state, 2);
      chk("R4 mute before last", mute, 1);
      phases(2, 0);
      chk("R4 state run", seq_state, 3);
      chk("R4 mute run", mute, 0);
   endtask

   task automatic t_lock_loss;
      ratio_lock = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 state", seq_state, 1);
      chk("R5 mute", mute, 1);
      ratio_lock = 1'b1;
      phases(10, 0);
      chk("R5 ramp restarted", seq_state, 2);
      phases(2, 0);
      chk("R5 run again", seq_state, 3);
   endtask

   task automatic t_frame_loss;
      repeat (100) @(negedge clk);
      chk("R6 state", seq_state, 0);
      chk("R6 mute", mute, 1);
      phases(14, 0);
      chk("R6 recovered", seq_state, 3);
   endtask

   task automatic t_deemph_on;
      shared_pin = 1'b0;
      phases(8, 0);
      chk("R9 four lows", deemph_en, 0);
      phases(2, 0);
      chk("R9 five lows", deemph_en, 1);
   endtask

   task automatic t_deemph_off;
      shared_pin = 1'b1;
      phases(8, 0);
      chk("R10 four highs", deemph_en, 1);
      phases(2, 0);
      chk("R10 five highs", deemph_en, 0);
   endtask

   task automatic t_deemph_speed;
      shared_pin = 1'b0;
      phases(10, 0);
      chk("R11 single on", deemph_en, 1);
      speed_mode = 2'd1;
      repeat (2) @(negedge clk);
      chk("R11 double", deemph_en, 0);
      speed_mode = 2'd2;
      repeat (2) @(negedge clk);
      chk("R11 quad", deemph_en, 0);
      speed_mode = 2'd0;
      repeat (2) @(negedge clk);
      chk("R11 single back", deemph_en, 1);
   endtask

   task automatic t_ext_entry;
      phases(2, 15);
      chk("R7 fifteen rises", ext_mode, 0);
      phase(16);
      chk("R7 sixteen rises", ext_mode, 1);
      chk("R11 ext blocks deemph", deemph_en, 0);
   endtask

   task automatic t_ext_exit;
      phases(2, 0);
      chk("R8 one frame idle", ext_mode, 1);
      phases(2, 0);
      chk("R8 two frames idle", ext_mode, 0);
      chk("R11 internal deemph back", deemph_en, 1);
      chk("R7 seq unaffected", seq_state, 3);
   endtask

   initial begin
      t_reset;
      t_no_frames;
      t_detect_wait;
      t_ramp_to_run;
      t_lock_loss;
      t_frame_loss;
      t_deemph_on;
      t_deemph_off;
      t_deemph_speed;
      t_ext_entry;
      t_ext_exit;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule